// File: doc/BRIEF.md
# History-Table Debug Word Compressor

This block sits in front of a slow serial link that carries debug-bus responses. Every response is a 36-bit word: a 4-bit type nibble on top and a 32-bit payload below it. An accepted word goes to the output register in uncompressed form on the next cycle. The output then waits for the link to take it. While it waits, the block reads a history of payloads it sent before, one entry per clock, newest first. The first entry that matches the pending payload turns the pending word into a short back-reference codeword. This can happen while the output is still stalled.

Only read-return words take part in this. Every other word type passes through untouched and never enters the history. A read-return word that leaves the block without a match becomes the newest history entry. The history is a circular RAM of 2^RAM_AW entries, but a reference can reach back only SHORT_N + LONG_N entries (9 + 512 = 521 by default). A clear strobe empties the history so that a host can resynchronise after it sets a new bus address.

Top module: `dwc_compressor`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the history is empty.
- R2: A word accepted with in_valid and in_ready appears unchanged on out_word one cycle later with out_valid high. in_ready stays low while out_valid is high. out_valid holds until out_ready accepts the word.
- R3: Only words whose type nibble (bits 35:32) is 4'h2 (read return) are searched or recorded. All other types leave the block bit-for-bit unchanged.
- R4: While the output is stalled, the search compares one history entry per clock, starting with age 1 (the newest) and moving to older entries. The first match rewrites the output and stops the search. out_valid stays high while this happens.
- R5: A match at age 1 to SHORT_N (9) gives type 4'hC with payload age-1 in the low bits and zeros above.
- R6: A match at age SHORT_N+1 (10) to SHORT_N+LONG_N (521) gives type 4'hD with payload age-10 in the low bits and zeros above. Age 521 therefore yields payload 511.
- R7: No entry older than age 521 ever matches, even though the RAM still holds it. The tracked history length saturates at 521.
- R8: A read-return word that is accepted without a match becomes the newest entry (age 1), and every older entry ages by one. A word that was rewritten into a reference is not recorded.
- R9: A one-cycle pulse on hist_clear sets the history length to zero. Entries written before the pulse never match afterwards.
- R10: If the output is accepted before any match is found, the word leaves uncompressed and is recorded per R8, even when an equal payload sits in the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hist_clear | input | 1 | Empties the history (new-address resynchronisation) |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 36 | Type nibble [35:32] and payload [31:0] |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Link accepts the output word |
| out_word | output | 36 | Uncompressed word or back-reference codeword |

## Verification
The embedded properties check several rules on every cycle. Pending output stays valid until it is accepted. A hit always produces one of the two reference types and ends the search. The compared age climbs by one each clock and stays within both the tracked length and the 521 window. The length saturates, and it falls to zero after a clear. Only the directed scenarios can show the values that come out. These are the exact codeword at the age 9/10 boundary, acceptance at age 521 and rejection at age 522 after 522 distinct payloads, the loss of matches after a clear, and the recording of a payload that was accepted before its search could finish.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  localparam int TYPE_W = 4;
  localparam int PAY_W  = 32;
  localparam int WORD_W = TYPE_W + PAY_W;

  // type nibble codes
  localparam logic [TYPE_W-1:0] T_READ      = 4'h2;
  localparam logic [TYPE_W-1:0] T_REF_SHORT = 4'hC;
  localparam logic [TYPE_W-1:0] T_REF_LONG  = 4'hD;

  // age counts from 1 (newest); short codes cover 1..short_n
  function automatic logic [WORD_W-1:0] f_ref_word(input int unsigned age,
                                                   input int unsigned short_n);
    logic [PAY_W-1:0] pay;
    if (age <= short_n) begin
      pay = PAY_W'(age - 1);
      return {T_REF_SHORT, pay};
    end
    pay = PAY_W'(age - short_n - 1);
    return {T_REF_LONG, pay};
  endfunction

  function automatic logic f_is_read(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: TYPE_W] == T_READ;
  endfunction

endpackage

// File: rtl/dwc_history_ram.sv
module dwc_history_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dwc_hist_ctrl.sv
module dwc_hist_ctrl #(
  parameter int AW      = 10,
  parameter int LEN_W   = 10,
  parameter int MAX_LEN = 521
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  output logic [AW-1:0]    wptr,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      len  <= '0;
    end else if (clear) begin
      len <= '0;
    end else if (push) begin
      wptr <= wptr + 1'b1;
      if (len != LEN_CAP) len <= len + 1'b1;
    end
  end

  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_CAP);

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> len == '0);

  p_push_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && len != LEN_CAP) |=> len == $past(len) + 1'b1);

endmodule

// File: rtl/dwc_search.sv
module dwc_search #(
  parameter int AW    = 10,
  parameter int LEN_W = 10,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DW-1:0]    key,
  input  logic [LEN_W-1:0] len,
  input  logic [AW-1:0]    wptr,
  output logic [AW-1:0]    raddr,
  input  logic [DW-1:0]    rdata,
  output logic             hit,
  output logic [LEN_W-1:0] hit_age,
  output logic             busy
);
  logic             iss_on;
  logic [LEN_W-1:0] iss_age;
  logic             cmp_on;
  logic [LEN_W-1:0] cmp_age;

  // newest entry sits just below the write pointer
  assign raddr   = wptr - AW'(iss_age);
  assign hit     = cmp_on && (rdata == key) && !abort;
  assign hit_age = cmp_age;
  assign busy    = iss_on || cmp_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_on  <= 1'b0;
      iss_age <= '0;
      cmp_on  <= 1'b0;
      cmp_age <= '0;
    end else if (abort || hit) begin
      iss_on <= 1'b0;
      cmp_on <= 1'b0;
    end else if (start) begin
      iss_on  <= (len != '0);
      iss_age <= LEN_W'(1);
      cmp_on  <= 1'b0;
    end else begin
      cmp_on  <= iss_on;
      cmp_age <= iss_age;
      if (iss_on) begin
        if (iss_age == len) iss_on <= 1'b0;
        else                iss_age <= iss_age + 1'b1;
      end
    end
  end

  p_age_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_on |-> (cmp_age >= LEN_W'(1)) && (cmp_age <= len));

  p_newest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_on && $past(cmp_on)) |-> cmp_age == $past(cmp_age) + 1'b1);

  p_first_hit_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !busy);

endmodule

// File: rtl/dwc_compressor.sv
module dwc_compressor #(
  parameter int RAM_AW  = 10,
  parameter int SHORT_N = 9,
  parameter int LONG_N  = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hist_clear,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [dwc_pkg::WORD_W-1:0] in_word,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [dwc_pkg::WORD_W-1:0] out_word
);
  import dwc_pkg::*;

  localparam int MAX_REACH = SHORT_N + LONG_N;
  localparam int LEN_W     = $clog2(MAX_REACH + 1);

  generate
    if (MAX_REACH > (1 << RAM_AW)) begin : g_reach_check
      $error("reach window larger than history RAM");
    end
  endgenerate

  logic              out_valid_q;
  logic [WORD_W-1:0] out_word_q;
  logic [PAY_W-1:0]  pend_pay;
  logic              pend_read;
  logic              pend_hit;

  // named events used by the logic and by the assertions
  logic in_fire, out_fire, start, abort, push;

  logic [RAM_AW-1:0] wptr, raddr;
  logic [LEN_W-1:0]  len, hit_age;
  logic [PAY_W-1:0]  rdata;
  logic              hit, busy;

  assign in_ready  = !out_valid_q;
  assign out_valid = out_valid_q;
  assign out_word  = out_word_q;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid_q && out_ready;
  assign start    = in_fire && f_is_read(in_word);
  assign abort    = out_fire || hist_clear;
  assign push     = out_fire && pend_read && !pend_hit && !hist_clear;

  dwc_hist_ctrl #(.AW(RAM_AW), .LEN_W(LEN_W), .MAX_LEN(MAX_REACH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(hist_clear), .push(push),
    .wptr(wptr), .len(len)
  );

  dwc_history_ram #(.AW(RAM_AW), .DW(PAY_W)) u_ram (
    .clk(clk), .we(push), .waddr(wptr), .wdata(pend_pay),
    .raddr(raddr), .rdata(rdata)
  );

  dwc_search #(.AW(RAM_AW), .LEN_W(LEN_W), .DW(PAY_W)) u_search (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .key(pend_pay),
    .len(len), .wptr(wptr), .raddr(raddr), .rdata(rdata),
    .hit(hit), .hit_age(hit_age), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
      pend_pay    <= '0;
      pend_read   <= 1'b0;
      pend_hit    <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid_q <= 1'b1;
        out_word_q  <= in_word;
        pend_pay    <= in_word[PAY_W-1:0];
        pend_read   <= f_is_read(in_word);
        pend_hit    <= 1'b0;
      end else if (hit) begin
        out_word_q <= f_ref_word(32'(hit_age), SHORT_N);
        pend_hit   <= 1'b1;
      end
      if (out_fire) out_valid_q <= 1'b0;
    end
  end

  p_hold_until_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_loaded_as_is_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_word == $past(in_word)) && out_valid);

  p_hit_makes_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (out_word[WORD_W-1 -: TYPE_W] == T_REF_SHORT) ||
            (out_word[WORD_W-1 -: TYPE_W] == T_REF_LONG));

  p_other_types_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fire && !pend_read) |=> $stable(out_word));

  p_no_search_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> out_valid);

endmodule

// File: tb/dwc_compressor_tb.sv
`timescale 1ns/1ps
module dwc_compressor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hist_clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [35:0] out_word;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dwc_compressor u_dut (
    .clk(clk), .rst_n(rst_n), .hist_clear(hist_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  localparam logic [31:0] PA = 32'hCAFE_0001;
  localparam logic [31:0] PB = 32'h0BAD_0002;
  localparam logic [31:0] PC = 32'h1234_5678;
  localparam int NV = 8;
  // stimulus word / expected output after a 16-cycle stall
  localparam logic [35:0] VIN [NV] = '{
    {4'h2, PA}, {4'h2, PB}, {4'h2, PA}, {4'h3, PB},
    {4'h2, PB}, {4'h2, PC}, {4'h2, PA}, {4'h1, PC}};
  localparam logic [35:0] VEXP [NV] = '{
    {4'h2, PA}, {4'h2, PB}, {4'hC, 32'd1}, {4'h3, PB},
    {4'hC, 32'd0}, {4'h2, PC}, {4'hC, 32'd2}, {4'h1, PC}};

  task automatic chk(input bit ok, input string req,
                     input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [35:0] w, input int stall,
                      input logic [35:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    // R2: word on output at once, unchanged, input blocked
    chk(out_valid && !in_ready, "R2 valid/ready", {34'd0, out_valid, in_ready}, 36'd2);
    chk(out_word == w, "R2 passthrough", out_word, w);
    repeat (stall) @(negedge clk);
    chk(out_valid, {req, " still valid"}, {35'd0, out_valid}, 36'd1);
    chk(out_word == exp, req, out_word, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); hist_clear = 1'b1;
    @(negedge clk); hist_clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset state", {34'd0, out_valid, in_ready}, 36'd1);

    // table walk: R3 passthrough types, R4/R5 short references, R8 recording
    for (int i = 0; i < NV; i++)
      send(VIN[i], 16, VEXP[i], "R3/R4/R5/R8 vector");

    // R9: after clear, PA must not match although it remains in RAM
    pulse_clear();
    send({4'h2, PA}, 16, {4'h2, PA}, "R9 cleared history");

    // R10: accepted before search finishes -> uncompressed and recorded
    send({4'h2, PB}, 0, {4'h2, PB}, "R10 record PB");
    send({4'h2, PA}, 0, {4'h2, PA}, "R10 early accept");
    send({4'h2, PB}, 16, {4'hC, 32'd1}, "R10 PA recorded so PB at age 2");

    // R5/R6 boundary: age 9 short, age 10 long
    pulse_clear();
    for (int i = 0; i < 10; i++)
      send({4'h2, 32'hF000_0000 + 32'(i)}, 0, {4'h2, 32'hF000_0000 + 32'(i)}, "R8 fill");
    send({4'h2, 32'hF000_0001}, 16, {4'hC, 32'd8}, "R5 age 9");
    send({4'h2, 32'hF000_0000}, 16, {4'hD, 32'd0}, "R6 age 10");

    // R6/R7: age 521 accepted, age 522 rejected
    pulse_clear();
    for (int i = 0; i < 522; i++)
      send({4'h2, 32'hA000_0000 + 32'(i)}, 0, {4'h2, 32'hA000_0000 + 32'(i)}, "R8 deep fill");
    send({4'h2, 32'hA000_0001}, 600, {4'hD, 32'd511}, "R6 age 521");
    send({4'h2, 32'hA000_0000}, 600, {4'h2, 32'hA000_0000}, "R7 age 522 rejected");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd1, 36'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule